// File: doc/BRIEF.md
# External Interrupt Request Logic

This block turns an active-low, asynchronous interrupt pin into an interrupt request for the CPU. A group of optional active-low port interrupt lines can also feed that request. Every input goes through a two-stage synchronizer in the CPU clock domain. A falling edge on the synchronized pin, or on any port line that is enabled, sets a shared pending latch. A strap input selects the sensing mode. In edge-only mode the latch alone forms the request. In edge-and-level mode the request is the latch OR a pin that is low right now. A global interrupt mask bit blocks the request from reaching the CPU. The latch keeps recording events while the mask is set.

The latch clears itself a fixed number of CPU clocks after the CPU reads the high byte of the interrupt vector. A falling edge that arrives during the service routine is therefore not lost. If the edge comes while the clear is still pending, it cancels that clear. If it comes on the clearing cycle or later, it sets the latch again. Either way a second request follows. All the pins in this block are plain control signals. No data stream crosses the block boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the pending latch and the clear timer, and sets every synchronizer stage to the idle high level. After reset, with all inputs high, `irq_req` is 0.
- R2: In edge-only mode (`level_mode`=0) the pin level is ignored. A falling edge on `irq_pin_n` sets the request after the third rising clock edge that follows the pin going low. The request stays set after the pin returns high. A pin that is held low raises no further request after the latch is cleared.
- R3: In edge-and-level mode (`level_mode`=1) the request rises after the second rising edge following the pin going low. It stays active while the pin is low, even when the latch is clear. It follows the latch once the pin is high again.
- R4: While `imask` is 1, `irq_req` is 0 in the same cycle. Events are still latched, and clearing `imask` exposes the pending request at once.
- R5: A read strobe (`vec_rd`=1) at address 0x3FFA, sampled on clock edge k, clears the latch on edge k+9. The latch stays set through edge k+8. Any other address, or an address of 0x3FFA without the strobe, does not clear the latch.
- R6: A falling edge that sets the latch while the clear is pending cancels the clear. An edge that lands on the clearing edge wins over the clear. An edge after the clear sets the latch again.
- R7: When `port_en`=1, a falling edge on any `port_n` bit sets the shared latch with the same timing as the pin. When `port_en`=0, port edges have no effect on `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| port_n | input | NPORT | Asynchronous active-low port interrupt lines |
| port_en | input | 1 | Strap: 1 lets port edges share the request |
| level_mode | input | 1 | Strap: 0 edge-only, 1 edge-and-level |
| imask | input | 1 | Global interrupt mask, 1 blocks the request |
| vec_rd | input | 1 | CPU read strobe |
| vec_addr | input | AW | CPU read address |
| irq_req | output | 1 | Interrupt request to the CPU, active high |

## Verification
Each result has a fixed cycle when it becomes due. A pin change is visible to the level path after the second rising edge. The edge latch reflects the change after the third. The mask acts combinationally within the same cycle. The clear lands on the ninth edge after the edge that sampled the vector read. The bench drives every input 1 ns after a rising edge and samples `irq_req` at that same offset after each following edge. It then compares the value with a count of edges computed from these figures. For the re-trigger case, the bench sweeps the arrival of a new edge across every offset from before the clear to after it. For each offset it predicts the latch state edge by edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic {
    SENSE_EDGE_ONLY  = 1'b0,
    SENSE_EDGE_LEVEL = 1'b1
  } sense_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_CLR_DELAY   = 9;
  localparam logic [15:0] DEF_VEC_HI      = 16'h3FFA;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_n;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_n = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_fall.sv
module ext_irq_fall #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_n,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= s_n;
  end

  assign fall = prev_q & ~s_n;

endmodule

// File: rtl/ext_irq_clr_timer.sv
module ext_irq_clr_timer #(
  parameter int unsigned DELAY = 9,
  parameter int unsigned CW    = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cancel,
  output logic          clr,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cancel)     cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign clr = (cnt == ONE);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NPORT       = 4,
  parameter int unsigned AW          = 16,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned CLR_DELAY   = DEF_CLR_DELAY,
  parameter logic [AW-1:0] VEC_ADDR  = AW'(DEF_VEC_HI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_n,
  input  logic             port_en,
  input  logic             level_mode,
  input  logic             imask,
  input  logic             vec_rd,
  input  logic [AW-1:0]    vec_addr,
  output logic             irq_req
);

  localparam int unsigned NSRC = NPORT + 1;
  localparam int unsigned CW   = $clog2(CLR_DELAY + 1);

  logic [NSRC-1:0] raw_n, sync_n, src_fall;
  logic            pin_s, pin_fall, port_set, set_ev;
  logic            vec_hit, clr_ev, latch_q, level_req;
  logic [CW-1:0]   cnt_q;
  sense_e          sense;

  assign raw_n = {port_n, irq_pin_n};

  ext_irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_n(raw_n), .q_n(sync_n)
  );

  ext_irq_fall #(.W(NSRC)) u_fall (
    .clk(clk), .rst_n(rst_n), .s_n(sync_n), .fall(src_fall)
  );

  assign pin_s    = sync_n[0];
  assign pin_fall = src_fall[0];
  assign port_set = port_en & (|src_fall[NSRC-1:1]);
  assign set_ev   = pin_fall | port_set;

  assign vec_hit  = vec_rd & (vec_addr == VEC_ADDR);

  ext_irq_clr_timer #(.DELAY(CLR_DELAY), .CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(vec_hit), .cancel(set_ev),
    .clr(clr_ev), .cnt(cnt_q)
  );

  // set has priority over the delayed clear
  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= 1'b0;
    else if (set_ev) latch_q <= 1'b1;
    else if (clr_ev) latch_q <= 1'b0;
  end

  assign sense     = sense_e'(level_mode);
  assign level_req = (sense == SENSE_EDGE_LEVEL) ? ~pin_s : 1'b0;
  assign irq_req   = ~imask & (latch_q | level_req);

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int unsigned CW        = 4,
  parameter int unsigned CLR_DELAY = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          level_mode,
  input logic          imask,
  input logic          irq_req,
  input logic          pin_s,
  input logic          set_ev,
  input logic          vec_hit,
  input logic          latch_q,
  input logic [CW-1:0] cnt_q
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!latch_q && cnt_q == '0));

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    imask |-> !irq_req);

  assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !latch_q) |-> !irq_req);

  assert_level_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !pin_s && !imask) |-> irq_req);

  assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |=> (cnt_q == CW'(CLR_DELAY)));

  assert_clear_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && !set_ev) |=> !latch_q);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> latch_q);

endmodule

bind ext_irq_ctrl ext_irq_chk #(.CW(CW), .CLR_DELAY(CLR_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .imask(imask),
  .irq_req(irq_req), .pin_s(pin_s), .set_ev(set_ev), .vec_hit(vec_hit),
  .latch_q(latch_q), .cnt_q(cnt_q)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;

  localparam int NPORT = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             irq_pin_n = 1'b1;
  logic [NPORT-1:0] port_n = '1;
  logic             port_en = 1'b0;
  logic             level_mode = 1'b0;
  logic             imask = 1'b0;
  logic             vec_rd = 1'b0;
  logic [15:0]      vec_addr = 16'h0000;
  logic             irq_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NPORT(NPORT)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_n(port_n),
    .port_en(port_en), .level_mode(level_mode), .imask(imask),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .irq_req(irq_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s %s: irq_req got %0b expected %0b", req, what, irq_req, exp);
    end
  endtask

  task automatic do_reset();
    irq_pin_n = 1'b1; port_n = '1; vec_rd = 1'b0; rst_n = 1'b0;
    steps(3);
    rst_n = 1'b1;
    step();
  endtask

  task automatic set_latch();
    irq_pin_n = 1'b1; steps(3);
    irq_pin_n = 1'b0; steps(2);
    irq_pin_n = 1'b1; steps(3);
  endtask

  // strobe sampled on the next edge (k); returns after edge k
  task automatic vec_read(input logic [15:0] a, input logic rd);
    vec_rd = rd; vec_addr = a;
    step();
    vec_rd = 1'b0; vec_addr = 16'h0000;
  endtask

  initial begin
    // R1: reset state
    level_mode = 1'b1;
    do_reset();
    check(1'b0, "R1", "after reset level mode");
    level_mode = 1'b0;
    check(1'b0, "R1", "after reset edge mode");

    // R2 R3 R4 R5: sweep mode x mask
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 2; k++) begin
        level_mode = m[0]; imask = k[0];
        do_reset();
        check(1'b0, "R1", "reset in sweep");
        irq_pin_n = 1'b0;
        step(); check(1'b0, "R3", "one edge after pin low");
        step(); check(m[0] & ~k[0], "R3", "two edges after pin low");
        step(); check(~k[0], "R2", "latched after three edges");
        irq_pin_n = 1'b1;
        steps(3); check(~k[0], "R2", "latch holds after pin high");
        imask = 1'b0; #1;
        check(1'b1, "R4", "unmask exposes pending");
        imask = k[0]; #1;
        vec_read(16'h3FFA, 1'b1);
        check(~k[0], "R5", "edge k after read");
        for (int t = 1; t < 9; t++) begin
          step(); check(~k[0], "R5", "latch before clear");
        end
        step(); check(1'b0, "R5", "cleared on ninth edge");
        imask = 1'b0;
      end
    end

    // R2 R3: pin held low through the clear
    for (int m = 0; m < 2; m++) begin
      level_mode = m[0];
      do_reset();
      irq_pin_n = 1'b0; steps(3);
      vec_read(16'h3FFA, 1'b1);
      steps(9);
      check(m[0], m[0] ? "R3" : "R2", "pin low after clear");
      steps(6);
      check(m[0], m[0] ? "R3" : "R2", "no retrigger while held low");
      irq_pin_n = 1'b1; steps(2);
      check(1'b0, "R3", "pin released after clear");
    end

    // R5: address sweep and strobe qualification
    level_mode = 1'b0;
    do_reset();
    for (int a = 16'h3FF8; a <= 16'h3FFF; a++) begin
      set_latch();
      vec_read(a[15:0], 1'b1);
      steps(10);
      check((a != 16'h3FFA), "R5", $sformatf("read addr %h", a));
      if (a != 16'h3FFA) begin
        vec_read(16'h3FFA, 1'b1); steps(10);
      end
    end
    set_latch();
    vec_read(16'h3FFA, 1'b0);
    steps(10);
    check(1'b1, "R5", "address without strobe");
    vec_read(16'h3FFA, 1'b1); steps(10);

    // R6: new edge at every offset relative to the clear
    for (int o = 1; o <= 12; o++) begin
      set_latch();
      for (int t = -2; t <= 14; t++) begin
        vec_rd    = (t == 0);
        vec_addr  = (t == 0) ? 16'h3FFA : 16'h0000;
        irq_pin_n = (t >= o - 2) ? 1'b0 : 1'b1;
        step();
        if (t >= 0)
          check((o <= 9) ? 1'b1 : ((t < 9) || (t >= o)), "R6",
                $sformatf("offset %0d edge %0d", o, t));
      end
      vec_rd = 1'b0; irq_pin_n = 1'b1;
      steps(3);
      vec_read(16'h3FFA, 1'b1); steps(10);
    end

    // R7: port lines, enabled and disabled
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < NPORT; b++) begin
        port_en = e[0];
        do_reset();
        port_n[b] = 1'b0;
        steps(2); check(1'b0, "R7", "port two edges");
        step();   check(e[0], "R7", $sformatf("port bit %0d en %0d", b, e));
        port_n[b] = 1'b1;
        steps(3); check(e[0], "R7", "port latch held");
      end
    end
    port_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule